// File: doc/BRIEF.md
# Auto-Reload Timer/Counter

This block is a 16-bit up-counter with a hidden 16-bit reload value. The live count and the reload value sit behind the same two byte addresses of a small byte-wide register port. While the timer is stopped, a write to a count byte sets both the live byte and its hidden reload partner. While it runs, the write reaches only the hidden partner. The next overflow then picks up the new reload value with no gap in the count. Reads always return the live count.

The count source is either an internal tick or rising edges on an external pulse pin. The internal tick comes from the system clock through an 8-bit prescaler and then a divide-by-12 or divide-by-1 stage. Each time the count wraps past its maximum it does three things: it loads the reload value, sets a sticky interrupt flag and, if enabled, toggles a clock-output pin. A driver sets the prescaler and the reload value, starts the timer through the control byte, and clears the flag from its interrupt handler.

Top module: `reload_timer16`

## Requirements
- R1: After reset, the live count, reload value, prescaler and control byte read as 0, and `irq` and `clk_out` are low.
- R2: In timer mode (control bit 1 = 0) with the rate bit (control bit 2) at 0, the count advances once every 12*(P+1) clocks, where P is the prescaler value at address 3.
- R3: With the rate bit at 1, the internal count advances once every P+1 clocks.
- R4: In counter mode (control bit 1 = 1), the count advances once per rising edge of `ext_pin`. The pin is synchronised through two flops and produces at most one step per clock.
- R5: While the run bit (control bit 0) is 0, a write to address 0 (low byte) or address 1 (high byte) sets both that live count byte and the matching reload byte.
- R6: While the run bit is 1, a write to address 0 or 1 changes only the reload byte. The live count keeps counting as before.
- R7: `rdata` is registered: one clock after `addr` is presented, it holds the register's value. Address 0/1 return the live count, never the reload. Address 2 returns {flag, 3'b0, clock-out enable, rate, source select, run}. Address 3 returns the prescaler.
- R8: A step taken at count 0xFFFF loads the count from the reload value and sets the flag (`irq`, control bit 7) on the same edge.
- R9: Each overflow toggles `clk_out` when the clock-out enable (control bit 3) is 1. When that bit is 0, `clk_out` holds its value.
- R10: The flag stays set until a control write with bit 7 = 0. A write with bit 7 = 1 has no effect on it, and an overflow on the same edge as a clearing write leaves it set.
- R11: While the run bit is 0, the count does not move, and the prescaler and divide-by-12 stage are held at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 count low, 1 count high, 2 control, 3 prescaler |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data for `addr` |
| ext_pin | input | 1 | External pulse input for counter mode |
| clk_out | output | 1 | Toggles on each overflow when enabled |
| irq | output | 1 | Sticky overflow flag |

## Verification
A wrong prescaler or divider phase shows up as a shifted overflow, visible on `irq` and `clk_out` within one tick period. Live reads show it even earlier, as a count that is off by one. A reload byte corrupted by a write while running stays hidden until the next wrap. It then appears as the wrong high byte on the read port, so the bench makes every reload path wrap and reads the count back. The bench's model predicts `rdata`, `irq` and `clk_out` on every clock, so any state error is reported on the first clock at which it reaches a port.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  typedef enum logic [1:0] {
    SEL_CNT_LO = 2'd0,
    SEL_CNT_HI = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_PRESC  = 2'd3
  } reg_sel_e;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_EXT  = 1;
  localparam int unsigned BIT_FAST = 2;
  localparam int unsigned BIT_CKEN = 3;
endpackage

// File: rtl/rtmr_tick_gen.sv
module rtmr_tick_gen #(
  parameter int unsigned PS_W     = 8,
  parameter int unsigned SLOW_DIV = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            ext_sel,
  input  logic            fast,
  input  logic [PS_W-1:0] presc,
  input  logic            ext_pin,
  output logic            step
);
  localparam int unsigned DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SLOW_DIV - 1);

  logic [PS_W-1:0]  pcnt;
  logic [DIV_W-1:0] dcnt;
  logic [2:0]       sync_q;
  logic             pre_tick;
  logic             div_done;
  logic             int_tick;
  logic             pin_rise;

  assign pre_tick = run && (pcnt >= presc);
  assign div_done = (dcnt == DIV_LAST);
  assign int_tick = pre_tick && (fast || div_done);
  assign pin_rise = sync_q[1] && !sync_q[2];
  assign step     = run && (ext_sel ? pin_rise : int_tick);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (pre_tick) begin
      pcnt <= '0;
      if (!fast) dcnt <= div_done ? '0 : dcnt + 1'b1;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], ext_pin};
  end
endmodule

// File: rtl/rtmr_count_core.sv
module rtmr_count_core #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run,
  input  logic                step,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                clk_en,
  input  logic                flag_clr,
  output logic [2*DATA_W-1:0] count,
  output logic [2*DATA_W-1:0] reload,
  output logic                ovf,
  output logic                irq,
  output logic                clk_out
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  assign ovf = step && (&count);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (!run && (wr_lo || wr_hi)) begin
      if (wr_lo) count[DATA_W-1:0]     <= wdata;
      if (wr_hi) count[CNT_W-1:DATA_W] <= wdata;
    end else if (step) begin
      count <= ovf ? reload : count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload <= '0;
    end else begin
      if (wr_lo) reload[DATA_W-1:0]     <= wdata;
      if (wr_hi) reload[CNT_W-1:DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq     <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      if (ovf)           irq <= 1'b1;
      else if (flag_clr) irq <= 1'b0;
      if (ovf && clk_en) clk_out <= !clk_out;
    end
  end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16 #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned SLOW_DIV = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_pin,
  output logic              clk_out,
  output logic              irq
);
  import rtmr_pkg::*;

  localparam int unsigned CNT_W    = 2 * DATA_W;
  localparam int unsigned BIT_FLAG = DATA_W - 1;

  reg_sel_e            sel;
  logic                run_q, ext_q, fast_q, cken_q;
  logic [DATA_W-1:0]   presc_q;
  logic                wr_lo, wr_hi, wr_ctrl, wr_presc, flag_clr;
  logic                step, ovf;
  logic [CNT_W-1:0]    count, reload;
  logic [DATA_W-1:0]   ctrl_view;
  logic [DATA_W-1:0]   rd_mux;

  assign sel      = reg_sel_e'(addr);
  assign wr_lo    = wr_en && (sel == SEL_CNT_LO);
  assign wr_hi    = wr_en && (sel == SEL_CNT_HI);
  assign wr_ctrl  = wr_en && (sel == SEL_CTRL);
  assign wr_presc = wr_en && (sel == SEL_PRESC);
  assign flag_clr = wr_ctrl && !wdata[BIT_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      ext_q   <= 1'b0;
      fast_q  <= 1'b0;
      cken_q  <= 1'b0;
      presc_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q  <= wdata[BIT_RUN];
        ext_q  <= wdata[BIT_EXT];
        fast_q <= wdata[BIT_FAST];
        cken_q <= wdata[BIT_CKEN];
      end
      if (wr_presc) presc_q <= wdata;
    end
  end

  rtmr_tick_gen #(.PS_W(DATA_W), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .run     (run_q),
    .ext_sel (ext_q),
    .fast    (fast_q),
    .presc   (presc_q),
    .ext_pin (ext_pin),
    .step    (step)
  );

  rtmr_count_core #(.DATA_W(DATA_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .run      (run_q),
    .step     (step),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wdata    (wdata),
    .clk_en   (cken_q),
    .flag_clr (flag_clr),
    .count    (count),
    .reload   (reload),
    .ovf      (ovf),
    .irq      (irq),
    .clk_out  (clk_out)
  );

  always_comb begin
    ctrl_view            = '0;
    ctrl_view[BIT_RUN]   = run_q;
    ctrl_view[BIT_EXT]   = ext_q;
    ctrl_view[BIT_FAST]  = fast_q;
    ctrl_view[BIT_CKEN]  = cken_q;
    ctrl_view[BIT_FLAG]  = irq;
    unique case (sel)
      SEL_CNT_LO: rd_mux = count[DATA_W-1:0];
      SEL_CNT_HI: rd_mux = count[CNT_W-1:DATA_W];
      SEL_CTRL:   rd_mux = ctrl_view;
      default:    rd_mux = presc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/rtmr_checker.sv
module rtmr_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             step,
  input logic             ovf,
  input logic             cnt_wr,
  input logic             clk_en,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             irq,
  input logic             clk_out
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && reload == '0 && !irq && !clk_out && !run));

  assert_step_increments_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !(&count)) |=> (count == $past(count) + 1'b1));

  assert_step_needs_run_R4: assert property (@(posedge clk) disable iff (rst)
    step |-> run);

  assert_running_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (run && !step) |=> $stable(count));

  assert_overflow_reload_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> (irq && count == $past(reload)));

  assert_clkout_toggle_R9: assert property (@(posedge clk) disable iff (rst)
    (ovf && clk_en) |=> (clk_out != $past(clk_out)));

  assert_clkout_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(ovf && clk_en) |=> $stable(clk_out));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && !flag_clr) |=> irq);

  assert_stopped_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!run && !cnt_wr) |=> $stable(count));
endmodule

bind reload_timer16 rtmr_checker #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .run      (run_q),
  .step     (step),
  .ovf      (ovf),
  .cnt_wr   (wr_lo || wr_hi),
  .clk_en   (cken_q),
  .flag_clr (flag_clr),
  .count    (count),
  .reload   (reload),
  .irq      (irq),
  .clk_out  (clk_out)
);

// File: tb/tb_reload_timer16.sv
module tb_reload_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic       ext_pin = 1'b0;
  logic [7:0] rdata;
  logic       clk_out, irq;

  always #10 clk = ~clk;

  reload_timer16 dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_pin(ext_pin), .clk_out(clk_out), .irq(irq)
  );

  int    total = 0;
  int    bad = 0;
  int    cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_cnt, m_rl, m_ps, m_pc, m_dc, m_rd, old_rl;
  bit m_run, m_ext, m_fast, m_cken, m_irq, m_ck;
  bit s1, s2, s3, edg, pre, tick, stepb, ov, w_lo, w_hi, w_ct, w_ps;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_rl = 0; m_ps = 0; m_pc = 0; m_dc = 0; m_rd = 0;
      m_run = 0; m_ext = 0; m_fast = 0; m_cken = 0; m_irq = 0; m_ck = 0;
      s1 = 0; s2 = 0; s3 = 0;
    end else begin
      w_lo = wr_en && addr == 2'd0;
      w_hi = wr_en && addr == 2'd1;
      w_ct = wr_en && addr == 2'd2;
      w_ps = wr_en && addr == 2'd3;
      edg   = s2 && !s3;
      pre   = m_run && (m_pc >= m_ps);
      tick  = pre && (m_fast || m_dc == 11);
      stepb = m_run && (m_ext ? edg : tick);
      ov    = stepb && m_cnt == 65535;
      case (addr)
        2'd0: m_rd = m_cnt % 256;
        2'd1: m_rd = m_cnt / 256;
        2'd2: m_rd = m_irq * 128 + m_cken * 8 + m_fast * 4 + m_ext * 2 + m_run;
        default: m_rd = m_ps;
      endcase
      if (!m_run) begin m_pc = 0; m_dc = 0; end
      else if (pre) begin
        m_pc = 0;
        if (!m_fast) m_dc = (m_dc == 11) ? 0 : m_dc + 1;
      end else m_pc = m_pc + 1;
      old_rl = m_rl;
      if (w_lo) m_rl = (m_rl / 256) * 256 + wdata;
      if (w_hi) m_rl = (m_rl % 256) + wdata * 256;
      if (!m_run && (w_lo || w_hi)) begin
        if (w_lo) m_cnt = (m_cnt / 256) * 256 + wdata;
        if (w_hi) m_cnt = (m_cnt % 256) + wdata * 256;
      end else if (stepb) m_cnt = ov ? old_rl : m_cnt + 1;
      if (ov) m_irq = 1;
      else if (w_ct && !wdata[7]) m_irq = 0;
      if (ov && m_cken) m_ck = !m_ck;
      if (w_ct) begin
        m_run = wdata[0]; m_ext = wdata[1]; m_fast = wdata[2]; m_cken = wdata[3];
      end
      if (w_ps) m_ps = wdata;
      s3 = s2; s2 = s1; s1 = ext_pin;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check(rdata == m_rd[7:0], cur_req, rdata, m_rd);
      check(irq == m_irq, cur_req, irq, m_irq);
      check(clk_out == m_ck, cur_req, clk_out, m_ck);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 5000) begin @(negedge clk); n++; end
    check(irq == 1'b1, req, irq, 1);
  endtask

  task automatic toggle_period(input string req, output int per);
    bit prev;
    int n = 0;
    prev = clk_out;
    while (clk_out == prev && n < 2000) begin @(negedge clk); n++; end
    prev = clk_out;
    per = 0;
    while (clk_out == prev && per < 2000) begin @(negedge clk); per++; end
  endtask

  initial begin
    int v, v2, n, per;
    bit ck0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    cur_req = "R1";
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R1", v, 0);
    end
    check(irq == 0 && clk_out == 0, "R1", {irq, clk_out}, 0);

    cur_req = "R5";
    wr(2'd0, 8'hF0);
    wr(2'd1, 8'hFF);
    rd(2'd0, v); check(v == 8'hF0, "R7", v, 8'hF0);
    rd(2'd1, v); check(v == 8'hFF, "R5", v, 8'hFF);

    // fast, prescaler 0, clock out enabled: 16 steps from 0xFFF0 to overflow
    cur_req = "R8";
    wr(2'd2, 8'h0D);
    n = 0;
    while (!irq && n < 100) begin @(negedge clk); n++; end
    check(n == 16, "R8", n, 16);
    check(clk_out == 1'b1, "R9", clk_out, 1);

    cur_req = "R10";
    wr(2'd2, 8'h00);
    check(irq == 1'b0, "R10", irq, 0);
    cur_req = "R11";
    rd(2'd0, v);
    repeat (6) @(negedge clk);
    rd(2'd0, v2);
    check(v == v2, "R11", v2, v);

    // write while running goes to reload only
    cur_req = "R6";
    wr(2'd3, 8'd200);
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h55);
    wr(2'd1, 8'h66);
    rd(2'd1, v); check(v == 8'hFF, "R6", v, 8'hFF);
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h05);
    cur_req = "R8";
    wait_irq("R8");
    wr(2'd2, 8'h00);
    rd(2'd1, v); check(v == 8'h66, "R8", v, 8'h66);

    // slow rate, prescaler 2: period 36
    cur_req = "R2";
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd3, 8'd2);
    wr(2'd2, 8'h09);
    toggle_period("R2", per);
    check(per == 36, "R2", per, 36);

    // fast rate, prescaler 4: period 5
    cur_req = "R3";
    wr(2'd2, 8'h00);
    wr(2'd3, 8'd4);
    wr(2'd2, 8'h0D);
    toggle_period("R3", per);
    check(per == 5, "R3", per, 5);

    // clock output disabled holds
    cur_req = "R9";
    wr(2'd2, 8'h05);
    ck0 = clk_out;
    repeat (50) @(negedge clk);
    check(irq == 1'b1, "R8", irq, 1);
    check(clk_out == ck0, "R9", clk_out, ck0);

    // sticky flag and clear-vs-overflow priority
    cur_req = "R10";
    wr(2'd2, 8'h85);
    check(irq == 1'b1, "R10", irq, 1);
    wr(2'd3, 8'd0);
    wr(2'd2, 8'h05);
    check(irq == 1'b1, "R10", irq, 1);
    wr(2'd2, 8'h00);
    check(irq == 1'b1, "R10", irq, 1);
    wr(2'd2, 8'h00);
    check(irq == 1'b0, "R10", irq, 0);

    // counter mode: five pin pulses
    cur_req = "R4";
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h10);
    wr(2'd2, 8'h03);
    for (int p = 0; p < 5; p++) begin
      ext_pin = 1'b1; repeat (3) @(negedge clk);
      ext_pin = 1'b0; repeat (3) @(negedge clk);
    end
    ext_pin = 1'b1; repeat (10) @(negedge clk);
    repeat (4) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd0, v); check(v == 6, "R4", v, 6);
    rd(2'd1, v); check(v == 8'h10, "R4", v, 8'h10);
    ext_pin = 1'b0;

    cur_req = "R11";
    for (int p = 0; p < 2; p++) begin
      ext_pin = 1'b1; repeat (3) @(negedge clk);
      ext_pin = 1'b0; repeat (3) @(negedge clk);
    end
    rd(2'd0, v); check(v == 6, "R11", v, 6);

    cur_req = "R7";
    wr(2'd2, 8'h0E);
    rd(2'd2, v); check(v == 8'h0E, "R7", v, 8'h0E);
    rd(2'd3, v); check(v == 0, "R7", v, 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule